// File: doc/BRIEF.md
# Programmable CRC32 Engine

This block is a register-mapped CRC engine with a 32-bit generator. Software sets a generator polynomial and a seed, issues a reset command that copies the seed into the accumulator, and then writes data as full words or as single bytes. Word and byte writes may be mixed freely within one computation. Each write updates the accumulator in a single clock, so the result can be read back in the next cycle.

The input can be bit-reversed in one of two ways, either within each byte or across the whole word. The output can also be bit-reversed. With these settings the same datapath produces both reflected checksums (such as CRC-32 and CRC-32C) and non-reflected ones.

Reading the data register returns the running accumulator. Software can therefore park a computation and resume it later: it writes the saved value back as the seed and resets.

Top module: `crc32_engine`

## Requirements
- R1: After reset the seed register reads 0xFFFFFFFF, the polynomial register reads 0x04C11DB7, the control register reads 0 and the data register reads 0xFFFFFFFF.
- R2: A control write (offset 0x08, strobe bit 0 set) with wdata bit 0 high copies the seed into the accumulator. Control bit 0 always reads back as 0.
- R3: Control bits [6:5] set the input order for word writes: 00 none, 01 bits reversed inside each byte, 11 all 32 bits reversed, 10 none. For byte writes the byte is bit-reversed whenever bit 5 is set.
- R4: When control bit 7 is set, a read of the data register returns the accumulator with its 32 bits in reverse order.
- R5: A data write (offset 0x00) with all four strobes set shifts the four bytes in, bit 31 first. A data write with exactly one strobe set shifts in the byte of that lane, bit 7 first. The step is the MSB-first rule: feedback = acc[31] xor the data bit, shift left, and xor the polynomial when feedback is 1.
- R6: A data write whose strobe is neither 4'b1111 nor one-hot leaves the accumulator unchanged.
- R7: The data register read returns the updated CRC in the cycle after the write. Without a data write or a reset command the accumulator holds its value.
- R8: With output reversal off, writing a read-back accumulator value as the seed (offset 0x10) and resetting continues the computation with an unchanged final result.
- R9: Polynomial 0x04C11DB7 with word input reversal and output reversal gives 0x340BC6D9 for the ASCII string "123456789" from seed 0xFFFFFFFF. Polynomial 0x1EDC6F41 in the same setup gives 0x1CF96D7C.
- R10: Writes to the seed and polynomial registers (offset 0x14) update only the strobed byte lanes. A single control write that carries both the reset command and new reversal settings applies the new settings to the data that follows.
- R11: Reads of offsets other than 0x00, 0x08, 0x10 and 0x14 return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_sel | input | 1 | Bus access valid |
| bus_wr | input | 1 | Write when high, read when low |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_be | input | 4 | Byte-lane write strobes |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr, combinational |

## Verification
Two functions can fall in the same cycle: the reset command that reloads the accumulator and the update of the reversal mode, because both come from one control write. The bench issues that combined write and then feeds a word. The result must match a seed-based CRC taken with the new byte-reversal mode, not the old mode. The bench also sends a data read in the cycle right after each feed, which confirms that the update completes within that single clock.

// File: rtl/crc32_pkg.sv
package crc32_pkg;
    localparam int unsigned CRC_W  = 32;
    localparam int unsigned BYTE_W = 8;
    localparam int unsigned LANES  = CRC_W / BYTE_W;

    localparam int unsigned OFF_DATA = 'h00;
    localparam int unsigned OFF_CTRL = 'h08;
    localparam int unsigned OFF_SEED = 'h10;
    localparam int unsigned OFF_POLY = 'h14;

    typedef enum logic [1:0] {
        REV_NONE = 2'b00,
        REV_BYTE = 2'b01,
        REV_RSVD = 2'b10,
        REV_WORD = 2'b11
    } rev_mode_e;

    typedef struct packed {
        logic [CRC_W-1:0] acc;
        logic [CRC_W-1:0] seed;
        logic [CRC_W-1:0] poly;
        rev_mode_e        rev_in;
        logic             rev_out;
    } eng_state_t;

    function automatic logic [CRC_W-1:0] flip_word(input logic [CRC_W-1:0] v);
        logic [CRC_W-1:0] r;
        for (int i = 0; i < CRC_W; i++) r[i] = v[CRC_W-1-i];
        return r;
    endfunction

    function automatic logic [CRC_W-1:0] lane_merge(input logic [CRC_W-1:0] old_v,
                                                    input logic [CRC_W-1:0] new_v,
                                                    input logic [LANES-1:0] strb);
        logic [CRC_W-1:0] r;
        r = old_v;
        for (int l = 0; l < LANES; l++)
            if (strb[l]) r[l*BYTE_W +: BYTE_W] = new_v[l*BYTE_W +: BYTE_W];
        return r;
    endfunction
endpackage

// File: rtl/crc32_advance.sv
module crc32_advance #(
    parameter int unsigned CRC_W  = 32,
    parameter int unsigned DATA_W = 32
) (
    input  logic [CRC_W-1:0]  crc_i,
    input  logic [CRC_W-1:0]  poly_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [CRC_W-1:0]  crc_o
);
    always_comb begin
        logic [CRC_W-1:0] c;
        logic             fb;
        c = crc_i;
        for (int i = DATA_W - 1; i >= 0; i--) begin
            fb = c[CRC_W-1] ^ data_i[i];
            c  = {c[CRC_W-2:0], 1'b0};
            if (fb) c = c ^ poly_i;
        end
        crc_o = c;
    end
endmodule

// File: rtl/crc32_in_shaper.sv
module crc32_in_shaper
    import crc32_pkg::*;
(
    input  logic [CRC_W-1:0]  data_i,
    input  logic [LANES-1:0]  strb_i,
    input  rev_mode_e         mode_i,
    output logic [CRC_W-1:0]  word_o,
    output logic [BYTE_W-1:0] byte_o,
    output logic              word_ok_o,
    output logic              byte_ok_o
);
    logic [CRC_W-1:0] per_byte_rev;
    logic [CRC_W-1:0] whole_rev;

    for (genvar l = 0; l < LANES; l++) begin : g_lane
        for (genvar b = 0; b < BYTE_W; b++) begin : g_bit
            assign per_byte_rev[l*BYTE_W + b] = data_i[l*BYTE_W + BYTE_W - 1 - b];
        end
    end

    for (genvar i = 0; i < CRC_W; i++) begin : g_word
        assign whole_rev[i] = data_i[CRC_W-1-i];
    end

    assign word_ok_o = &strb_i;
    assign byte_ok_o = $onehot(strb_i);

    always_comb begin
        unique case (mode_i)
            REV_BYTE: word_o = per_byte_rev;
            REV_WORD: word_o = whole_rev;
            default:  word_o = data_i;
        endcase
    end

    always_comb begin
        logic [BYTE_W-1:0] sel;
        sel = '0;
        for (int l = 0; l < LANES; l++)
            if (strb_i[l]) sel = sel | data_i[l*BYTE_W +: BYTE_W];
        for (int b = 0; b < BYTE_W; b++)
            byte_o[b] = mode_i[0] ? sel[BYTE_W-1-b] : sel[b];
    end
endmodule

// File: rtl/crc32_engine.sv
module crc32_engine
    import crc32_pkg::*;
#(
    parameter int unsigned ADDR_W   = 5,
    parameter logic [31:0] SEED_RST = 32'hFFFF_FFFF,
    parameter logic [31:0] POLY_RST = 32'h04C1_1DB7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [3:0]        bus_be,
    input  logic [31:0]       bus_wdata,
    output logic [31:0]       bus_rdata
);
    localparam logic [ADDR_W-1:0] A_DATA = ADDR_W'(OFF_DATA);
    localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFF_CTRL);
    localparam logic [ADDR_W-1:0] A_SEED = ADDR_W'(OFF_SEED);
    localparam logic [ADDR_W-1:0] A_POLY = ADDR_W'(OFF_POLY);

    eng_state_t state_d, state_q;

    logic [CRC_W-1:0]  feed_word;
    logic [BYTE_W-1:0] feed_byte;
    logic              word_ok, byte_ok;
    logic [CRC_W-1:0]  crc_after_word, crc_after_byte;
    logic              wr_en;

    assign wr_en = bus_sel & bus_wr;

    crc32_in_shaper u_shape (
        .data_i    (bus_wdata),
        .strb_i    (bus_be),
        .mode_i    (state_q.rev_in),
        .word_o    (feed_word),
        .byte_o    (feed_byte),
        .word_ok_o (word_ok),
        .byte_ok_o (byte_ok)
    );

    crc32_advance #(.CRC_W(CRC_W), .DATA_W(CRC_W)) u_adv_word (
        .crc_i  (state_q.acc),
        .poly_i (state_q.poly),
        .data_i (feed_word),
        .crc_o  (crc_after_word)
    );

    crc32_advance #(.CRC_W(CRC_W), .DATA_W(BYTE_W)) u_adv_byte (
        .crc_i  (state_q.acc),
        .poly_i (state_q.poly),
        .data_i (feed_byte),
        .crc_o  (crc_after_byte)
    );

    always_comb begin
        state_d = state_q;
        if (wr_en) begin
            unique case (bus_addr)
                A_DATA: begin
                    if (word_ok)      state_d.acc = crc_after_word;
                    else if (byte_ok) state_d.acc = crc_after_byte;
                end
                A_CTRL: begin
                    if (bus_be[0]) begin
                        state_d.rev_in  = rev_mode_e'(bus_wdata[6:5]);
                        state_d.rev_out = bus_wdata[7];
                        if (bus_wdata[0]) state_d.acc = state_q.seed;
                    end
                end
                A_SEED:  state_d.seed = lane_merge(state_q.seed, bus_wdata, bus_be);
                A_POLY:  state_d.poly = lane_merge(state_q.poly, bus_wdata, bus_be);
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q.acc     <= SEED_RST;
            state_q.seed    <= SEED_RST;
            state_q.poly    <= POLY_RST;
            state_q.rev_in  <= REV_NONE;
            state_q.rev_out <= 1'b0;
        end else begin
            state_q <= state_d;
        end
    end

    always_comb begin
        unique case (bus_addr)
            A_DATA:  bus_rdata = state_q.rev_out ? flip_word(state_q.acc) : state_q.acc;
            A_CTRL:  bus_rdata = {24'h0, state_q.rev_out, state_q.rev_in, 5'b0};
            A_SEED:  bus_rdata = state_q.seed;
            A_POLY:  bus_rdata = state_q.poly;
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/crc32_engine_chk.sv
module crc32_engine_chk #(
    parameter int unsigned ADDR_W = 5
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [3:0]        bus_be,
    input logic [31:0]       bus_wdata,
    input logic [31:0]       bus_rdata,
    input logic [31:0]       acc_q,
    input logic [31:0]       seed_q,
    input logic [31:0]       poly_q
);
    logic wr, at_data, at_ctrl, at_seed, at_poly;
    assign wr      = bus_sel && bus_wr;
    assign at_data = bus_addr == ADDR_W'('h00);
    assign at_ctrl = bus_addr == ADDR_W'('h08);
    assign at_seed = bus_addr == ADDR_W'('h10);
    assign at_poly = bus_addr == ADDR_W'('h14);

    AST_RESET_LOADS_SEED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && at_ctrl && bus_be[0] && bus_wdata[0]) |=> (acc_q == $past(seed_q))); // R2
    AST_CTRL_RESET_BIT_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        at_ctrl |-> (bus_rdata[0] == 1'b0)); // R2
    AST_BAD_STROBE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && at_data && !(&bus_be) && !$onehot(bus_be)) |=> $stable(acc_q)); // R6
    AST_ACC_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && (at_data || at_ctrl)) |=> $stable(acc_q)); // R7
    AST_POLY_FULL_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr && at_poly && (&bus_be)) |=> (poly_q == $past(bus_wdata))); // R10
    AST_SEED_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr && at_seed) |=> $stable(seed_q)); // R10
    AST_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        !(at_data || at_ctrl || at_seed || at_poly) |-> (bus_rdata == 32'h0)); // R11
endmodule

bind crc32_engine crc32_engine_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_be    (bus_be),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .acc_q     (state_q.acc),
    .seed_q    (state_q.seed),
    .poly_q    (state_q.poly)
);

// File: tb/tb_crc32_engine.sv
module tb_crc32_engine;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bus_sel = 1'b0;
    logic          bus_wr = 1'b0;
    logic [AW-1:0] bus_addr = '0;
    logic [3:0]    bus_be = '0;
    logic [31:0]   bus_wdata = '0;
    logic [31:0]   bus_rdata;

    int n_checks = 0;
    int n_errors = 0;
    bit done = 1'b0;

    logic [31:0] m_acc, m_seed, m_poly;
    logic [1:0]  m_mode;
    logic        m_out;

    always #10 clk = ~clk;

    crc32_engine #(.ADDR_W(AW)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_be(bus_be), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata)
    );

    function automatic logic [7:0] r8(input logic [7:0] v);
        logic [7:0] o;
        for (int i = 0; i < 8; i++) o[i] = v[7-i];
        return o;
    endfunction

    function automatic logic [31:0] r32(input logic [31:0] v);
        logic [31:0] o;
        for (int i = 0; i < 32; i++) o[i] = v[31-i];
        return o;
    endfunction

    function automatic logic [31:0] step(input logic [31:0] c, input logic [31:0] p,
                                         input logic [31:0] d, input int n);
        logic [31:0] x;
        x = c;
        for (int i = n - 1; i >= 0; i--) begin
            if (x[31] ^ d[i]) x = (x << 1) ^ p;
            else              x = x << 1;
        end
        return x;
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
        end
    endtask

    task automatic wr(input int a, input logic [31:0] d, input logic [3:0] be);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = AW'(a); bus_be = be; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; bus_be = '0;
    endtask

    task automatic rd(input int a, output logic [31:0] d);
        bus_addr = AW'(a);
        #2;
        d = bus_rdata;
    endtask

    task automatic ctrl(input logic [1:0] mode, input logic outr, input logic rst);
        wr('h08, {24'h0, outr, mode, 4'h0, rst}, 4'hF);
        m_mode = mode; m_out = outr;
        if (rst) m_acc = m_seed;
    endtask

    task automatic feed_word(input logic [31:0] w);
        logic [31:0] s;
        wr('h00, w, 4'hF);
        s = w;
        if (m_mode == 2'b01) s = {r8(w[31:24]), r8(w[23:16]), r8(w[15:8]), r8(w[7:0])};
        else if (m_mode == 2'b11) s = r32(w);
        m_acc = step(m_acc, m_poly, s, 32);
    endtask

    task automatic feed_byte(input int lane, input logic [7:0] b);
        logic [7:0] s;
        wr('h00, {24'h0, b} << (8 * lane), 4'b0001 << lane);
        s = m_mode[0] ? r8(b) : b;
        m_acc = step(m_acc, m_poly, {24'h0, s}, 8);
    endtask

    task automatic expect_data(input string req);
        logic [31:0] v;
        rd('h00, v);
        chk(req, v, m_out ? r32(m_acc) : m_acc);
    endtask

    task automatic t_reset_values;
        logic [31:0] v;
        rd('h10, v); chk("R1 seed", v, 32'hFFFF_FFFF);
        rd('h14, v); chk("R1 poly", v, 32'h04C1_1DB7);
        rd('h08, v); chk("R1 ctrl", v, 32'h0);
        rd('h00, v); chk("R1 data", v, 32'hFFFF_FFFF);
    endtask

    task automatic t_word_plain;
        logic [31:0] v;
        ctrl(2'b00, 1'b0, 1'b1);
        rd('h08, v); chk("R2 reset bit self clears", v, 32'h0);
        rd('h00, v); chk("R2 accumulator loaded from seed", v, 32'hFFFF_FFFF);
        feed_word(32'h1234_5678); expect_data("R7 read after word");
        feed_word(32'hDEAD_BEEF); expect_data("R5 word MSB first");
    endtask

    task automatic t_byte_lanes;
        ctrl(2'b00, 1'b0, 1'b1);
        for (int l = 0; l < 4; l++) begin
            feed_byte(l, 8'hA5 ^ 8'(l * 37));
            expect_data("R5 byte lane");
        end
        feed_word(32'h0BAD_F00D); expect_data("R5 mixed word after bytes");
    endtask

    task automatic t_modes;
        for (int m = 0; m < 4; m++) begin
            ctrl(2'(m), 1'b0, 1'b1);
            feed_word(32'h8142_C3E7);
            feed_byte(2, 8'h1E);
            expect_data("R3 input reversal mode");
        end
    endtask

    task automatic t_outrev;
        ctrl(2'b11, 1'b1, 1'b1);
        feed_word(32'h0000_0001);
        expect_data("R4 output reversal");
    endtask

    task automatic t_bad_strobe;
        ctrl(2'b00, 1'b0, 1'b1);
        feed_word(32'hCAFE_0001);
        wr('h00, 32'h1111_2222, 4'b0011);
        wr('h00, 32'h3333_4444, 4'b0000);
        wr('h00, 32'h5555_6666, 4'b1010);
        expect_data("R6 bad strobe ignored");
    endtask

    task automatic t_resume;
        logic [31:0] saved, full;
        full = step(32'hFFFF_FFFF, m_poly, r32(32'h0102_0304), 32);
        full = step(full, m_poly, r32(32'hF0E0_D0C0), 32);
        wr('h10, 32'hFFFF_FFFF, 4'hF); m_seed = 32'hFFFF_FFFF;
        ctrl(2'b11, 1'b0, 1'b1);
        feed_word(32'h0102_0304);
        rd('h00, saved);
        ctrl(2'b11, 1'b0, 1'b1);
        feed_word(32'h7777_7777);
        wr('h10, saved, 4'hF); m_seed = saved;
        ctrl(2'b11, 1'b0, 1'b1);
        feed_word(32'hF0E0_D0C0);
        rd('h00, saved);
        chk("R8 resume from saved value", saved, full);
        wr('h10, 32'hFFFF_FFFF, 4'hF); m_seed = 32'hFFFF_FFFF;
    endtask

    task automatic t_standard(input logic [31:0] poly, input logic [31:0] exp, input string tag);
        logic [31:0] v;
        wr('h14, poly, 4'hF); m_poly = poly;
        ctrl(2'b11, 1'b1, 1'b1);
        feed_word(32'h3433_3231);
        feed_word(32'h3837_3635);
        feed_byte(0, 8'h39);
        rd('h00, v);
        chk(tag, v, exp);
    endtask

    task automatic t_combo_and_strobes;
        logic [31:0] v;
        ctrl(2'b11, 1'b0, 1'b0);
        wr('h14, 32'h04C1_1DB7, 4'hF); m_poly = 32'h04C1_1DB7;
        wr('h10, 32'h1234_5678, 4'b0101); m_seed = 32'hFF34_FF78;
        rd('h10, v); chk("R10 seed strobed lanes", v, 32'hFF34_FF78);
        wr('h08, 32'h0000_0021, 4'hF); m_mode = 2'b01; m_out = 1'b0; m_acc = m_seed;
        feed_word(32'h00FF_1080);
        expect_data("R10 reset with new mode");
        wr('h14, 32'hAABB_CCDD, 4'b1000);
        rd('h14, v); chk("R10 poly strobed lane", v, 32'hAAC1_1DB7);
    endtask

    task automatic t_unmapped;
        logic [31:0] v;
        rd('h04, v); chk("R11 unmapped 0x04", v, 32'h0);
        rd('h0C, v); chk("R11 unmapped 0x0C", v, 32'h0);
        rd('h18, v); chk("R11 unmapped 0x18", v, 32'h0);
    endtask

    task automatic finish_run;
        if (!done) begin
            done = 1'b1;
            $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
            $finish;
        end
    endtask

    initial begin
        m_acc = 32'hFFFF_FFFF; m_seed = 32'hFFFF_FFFF; m_poly = 32'h04C1_1DB7;
        m_mode = 2'b00; m_out = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_values;
        t_word_plain;
        t_byte_lanes;
        t_modes;
        t_outrev;
        t_bad_strobe;
        t_resume;
        t_standard(32'h04C1_1DB7, 32'h340B_C6D9, "R9 CRC-32 check value");
        t_standard(32'h1EDC_6F41, 32'h1CF9_6D7C, "R9 CRC-32C check value");
        t_combo_and_strobes;
        t_unmapped;
        finish_run;
    end

    initial begin
        #(20 * 200000);
        n_checks++;
        n_errors++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        finish_run;
    end
endmodule